// File: doc/BRIEF.md
# Receiver Detect and RX Reset Sequencer

This block follows the receiver-detect stage of link bring-up and produces the RX digital reset that comes after it. After reset it waits in a quiet state until the RX PLL reports lock. It then moves to an active detect state and watches the PHY for a status pulse. When that pulse arrives together with the "receiver present" receive-status code, the block enters the polling state.

On entry to polling the RX digital reset is asserted, as it is in every other state. It is released only after the signal-detect input has kept the same value for a programmable number of clock cycles. The default count equals 3 ms at 125 MHz, and a bench can shorten it. Any change on signal-detect restarts the count. Loss of PLL lock sends the block back to quiet and reasserts the reset.

Top module: `rx_detect_seq`

## Requirements
- R1: While rst_n is low and in the cycle after it rises, lt_state_o reads 0 (quiet) and rx_dig_rst_o reads 1.
- R2: In quiet, the state moves to active (1) at the first clock edge at which pll_lock_i is high; without lock it stays quiet.
- R3: In active with lock held, a clock edge that samples phy_status_i high with rx_status_i equal to 3'b011 moves the state to polling (2).
- R4: In active with lock held, phy_status_i with any rx_status_i other than 3'b011, or rx_status_i 3'b011 without phy_status_i, is ignored and the state stays active.
- R5: rx_dig_rst_o is 1 in quiet and active, and it is still 1 in the first cycle after entry to polling.
- R6: In polling, rx_dig_rst_o falls right after the HOLD_CYC-th clock edge following entry if sig_det_i holds its value at every one of those edges. Stability means an unchanged level; either level counts.
- R7: In polling, a clock edge that samples sig_det_i different from its previous sample clears the count. rx_dig_rst_o is then 1 until HOLD_CYC further stable edges have passed, and this also applies after a release.
- R8: A clock edge that samples pll_lock_i low in active or polling returns the state to quiet, and rx_dig_rst_o is 1 from then on.
- R9: lt_state_o uses quiet=0, active=1, polling=2 and never shows 3.
- R10: Once released, rx_dig_rst_o stays 0 for as long as lock holds and sig_det_i does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_lock_i | input | 1 | RX PLL lock indication |
| phy_status_i | input | 1 | PHY status pulse |
| rx_status_i | input | 3 | PHY receive status code |
| sig_det_i | input | 1 | Signal-detect level from the receiver |
| lt_state_o | output | 2 | Current state: 0 quiet, 1 active, 2 polling |
| rx_dig_rst_o | output | 1 | RX digital reset, active high |

## Verification
Receiver detection is driven with a PHY pulse carrying a wrong status code and with the right code but no pulse. Only the pulse and the code together may advance the state, so these cases separate a correct qualifier from one that looks at either signal alone. The stability timer is tried in three ways. A steady signal-detect level checks the exact release cycle against the hold count. A toggle partway through the window checks that the count restarts rather than pauses. A toggle after release checks that the reset reasserts. PLL lock is dropped once in active and once in polling, which shows that both states fall back to quiet and that the timer does not carry stale progress into the next entry.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  typedef enum logic [1:0] {
    LT_QUIET  = 2'd0,
    LT_ACTIVE = 2'd1,
    LT_POLL   = 2'd2
  } lt_state_e;

  localparam logic [2:0] RXSTAT_PRESENT = 3'b011;

  // Detection completes only on a PHY pulse carrying the "present" code.
  function automatic logic detect_hit(input logic phy, input logic [2:0] st);
    return phy && (st == RXSTAT_PRESENT);
  endfunction

  // Next state of the detect sequence.
  function automatic lt_state_e next_state(input lt_state_e cur, input logic lock,
                                           input logic hit);
    lt_state_e n;
    n = cur;
    case (cur)
      LT_QUIET:  n = lock ? LT_ACTIVE : LT_QUIET;
      LT_ACTIVE: n = !lock ? LT_QUIET : (hit ? LT_POLL : LT_ACTIVE);
      LT_POLL:   n = !lock ? LT_QUIET : LT_POLL;
      default:   n = LT_QUIET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rxd_fsm.sv
module rxd_fsm
  import rxd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pll_lock_i,
  input  logic      det_hit_i,
  output lt_state_e state_o,
  output logic      poll_entry_o
);

  lt_state_e state_q, state_d;

  always_comb state_d = next_state(state_q, pll_lock_i, det_hit_i);

  assign poll_entry_o = (state_q != LT_POLL) && (state_d == LT_POLL);
  assign state_o      = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LT_QUIET;
    else        state_q <= state_d;
  end

  // R2
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LT_QUIET && !pll_lock_i) |=> (state_q == LT_QUIET));

  // R3
  detect_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LT_ACTIVE && pll_lock_i && det_hit_i) |=> (state_q == LT_POLL));

endmodule

// File: rtl/rxd_stab_timer.sv
module rxd_stab_timer #(
  parameter int unsigned HOLD_CYC = 375000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic sig_det_i,
  output logic stable_o,
  output logic restart_o
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic          sd_q;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c == LIMIT) ? c : c + 1'b1;
  endfunction

  assign restart_o = run_i && (sig_det_i != sd_q);
  assign stable_o  = (cnt_q == LIMIT);

  always_comb begin
    if (!run_i || restart_o) cnt_d = '0;
    else                     cnt_d = bump(cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      sd_q  <= sig_det_i;
      cnt_q <= cnt_d;
    end
  end

  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> !stable_o);

  // R10
  stable_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && stable_o && !restart_o) |=> stable_o);

endmodule

// File: rtl/rx_detect_seq.sv
module rx_detect_seq #(
  parameter int unsigned HOLD_CYC = 375000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_lock_i,
  input  logic       phy_status_i,
  input  logic [2:0] rx_status_i,
  input  logic       sig_det_i,
  output logic [1:0] lt_state_o,
  output logic       rx_dig_rst_o
);
  import rxd_pkg::*;

  lt_state_e st;
  logic      det_hit;
  logic      poll_entry;
  logic      in_poll;
  logic      sd_stable;
  logic      sd_restart;

  assign det_hit = detect_hit(phy_status_i, rx_status_i);
  assign in_poll = (st == LT_POLL);

  rxd_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_lock_i   (pll_lock_i),
    .det_hit_i    (det_hit),
    .state_o      (st),
    .poll_entry_o (poll_entry)
  );

  rxd_stab_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (in_poll),
    .sig_det_i (sig_det_i),
    .stable_o  (sd_stable),
    .restart_o (sd_restart)
  );

  assign lt_state_o   = st;
  assign rx_dig_rst_o = !(in_poll && sd_stable);

  // R4
  ignore_bad_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_state_o == 2'd1 && pll_lock_i && !(phy_status_i && rx_status_i == 3'b011))
      |=> (lt_state_o == 2'd1));

  // R5
  poll_entry_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_entry |=> rx_dig_rst_o);

  // R8
  lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_state_o != 2'd0 && !pll_lock_i) |=> (lt_state_o == 2'd0 && rx_dig_rst_o));

  // R9
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lt_state_o != 2'd3);

  // R7
  restart_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_restart |=> rx_dig_rst_o);

endmodule

// File: tb/rx_detect_seq_bench.sv
`timescale 1ns/1ps
module rx_detect_seq_bench;

  localparam int unsigned HOLD = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lock = 1'b0;
  logic       phy = 1'b0;
  logic [2:0] rxs = 3'd0;
  logic       sd = 1'b0;
  logic [1:0] st_o;
  logic       rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Scoreboard queues
  logic [1:0] q_st[$];
  logic       q_rst[$];
  string      q_tag[$];

  // Reference model state
  int m_state = 0;
  int m_cnt = 0;
  logic m_sd = 1'b0;

  always #4 clk = ~clk;

  rx_detect_seq #(.HOLD_CYC(HOLD)) u_rx_detect_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_lock_i   (lock),
    .phy_status_i (phy),
    .rx_status_i  (rxs),
    .sig_det_i    (sd),
    .lt_state_o   (st_o),
    .rx_dig_rst_o (rst_o)
  );

  task automatic check(input string tag, input logic [1:0] a_st, input logic a_rst,
                       input logic [1:0] e_st, input logic e_rst);
    checks++;
    if (a_st !== e_st || a_rst !== e_rst) begin
      errors++;
      $display("FAIL %s state=%0d rst=%0b expected state=%0d rst=%0b",
               tag, a_st, a_rst, e_st, e_rst);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outcome.
  task automatic step(input logic l, input logic p, input logic [2:0] s,
                      input logic d, input string tag);
    int ns;
    int nc;
    lock = l; phy = p; rxs = s; sd = d;
    @(posedge clk);
    case (m_state)
      0:       ns = l ? 1 : 0;
      1:       ns = !l ? 0 : ((p && s == 3'd3) ? 2 : 1);
      default: ns = !l ? 0 : 2;
    endcase
    if (m_state != 2 || d != m_sd) nc = 0;
    else                           nc = (m_cnt >= HOLD) ? HOLD : m_cnt + 1;
    m_state = ns;
    m_cnt   = nc;
    m_sd    = d;
    q_st.push_back(2'(ns));
    q_rst.push_back(!(ns == 2 && nc == HOLD));
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic hold(input int n, input logic l, input logic d, input string tag);
    for (int i = 0; i < n; i++) step(l, 1'b0, 3'd0, d, tag);
  endtask

  // Monitor: compare design output against queued expectations.
  always @(negedge clk) begin
    if (q_st.size() > 0) begin
      logic [1:0] es;
      logic       er;
      string      et;
      es = q_st.pop_front();
      er = q_rst.pop_front();
      et = q_tag.pop_front();
      check(et, st_o, rst_o, es, er);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", st_o, rst_o, 2'd0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", st_o, rst_o, 2'd0, 1'b1);
    // R2: no lock keeps quiet, then lock advances
    hold(3, 1'b0, 1'b0, "R2 no lock");
    step(1'b1, 1'b0, 3'd0, 1'b0, "R2 lock");
    // R4: wrong code with pulse, right code without pulse
    step(1'b1, 1'b1, 3'd2, 1'b0, "R4 pulse bad code");
    step(1'b1, 1'b1, 3'd7, 1'b0, "R4 pulse code7");
    step(1'b1, 1'b0, 3'd3, 1'b0, "R4 code no pulse");
    // R8: lock loss in active
    step(1'b0, 1'b0, 3'd0, 1'b0, "R8 loss in active");
    step(1'b1, 1'b0, 3'd0, 1'b1, "R2 relock");
    // R3/R5: detection into polling
    step(1'b1, 1'b1, 3'd3, 1'b1, "R3 R5 detect");
    // R6: steady signal-detect releases after HOLD edges
    hold(HOLD + 1, 1'b1, 1'b1, "R6 steady high");
    // R10: stays released
    hold(4, 1'b1, 1'b1, "R10 hold");
    // R7: change after release reasserts; glitch midway restarts count
    hold(5, 1'b1, 1'b0, "R7 change low");
    step(1'b1, 1'b0, 3'd0, 1'b1, "R7 glitch");
    hold(HOLD + 2, 1'b1, 1'b1, "R7 restart");
    // R8: lock loss in polling
    step(1'b0, 1'b0, 3'd0, 1'b1, "R8 loss in poll");
    hold(2, 1'b0, 1'b1, "R8 quiet");
    // Re-entry checks that no stale count survives
    step(1'b1, 1'b0, 3'd0, 1'b1, "R2 lock again");
    step(1'b1, 1'b1, 3'd3, 1'b1, "R3 detect again");
    hold(HOLD + 1, 1'b1, 1'b1, "R6 fresh count");
    repeat (2) @(negedge clk);
    if (q_st.size() != 0) begin
      errors++;
      $display("FAIL R1 scoreboard left=%0d expected=0", q_st.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule